// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block sits on the host side of a serial successive-approximation converter and collects one 12-bit sample each time it is asked. It runs from the system clock. It drives the active-low chip-select and a serial clock whose half period is a programmable number of system cycles. It samples the converter's data line and checks the shape of the frame. A frame is sixteen bits, sent most significant first: four bits that must be zero, then the twelve data bits. The converter puts the first of these bits on the line when chip-select falls. Each later bit is advanced on a falling serial clock edge.

A single-cycle start request begins a frame. The divider, the frame length and the capture-edge choice are taken at that moment and held until the frame ends. A full frame delivers the data word with a one-cycle valid strobe. An error strobe is raised alongside it when any leading bit reads as one. A shorter frame raises chip-select early, which aborts the conversion, and its bits are thrown away. After every frame, chip-select stays high for one full serial clock period before the next request can be taken.

Top module: `sar_frame_reader`

## Requirements
- R1: In reset and after it, cs_n_o and sclk_o are 1, busy_o, valid_o and err_o are 0, and result_o is 0.
- R2: A start_i sampled high while busy_o is low is accepted. After that clock edge cs_n_o is 0, busy_o is 1 and sclk_o is still 1. A start held high across the end of a frame is accepted on the first edge at which the block is idle.
- R3: The serial clock half period is H system cycles, with H equal to div_i, or 1 when div_i is 0. The first falling edge of sclk_o comes H edges after the accepting edge. sclk_o then toggles every H edges, and it is 1 whenever cs_n_o is 1.
- R4: A frame lasts L serial clocks, with L equal to len_i for values 1 to 16, and 16 for 0 or any value above 16. cs_n_o rises on the same edge as the L-th rising edge of sclk_o, which is 2·L·H edges after acceptance.
- R5: With edge_sel_i = 0, frame bit k-1 is taken from sdata_i on the k-th falling edge, for k = 1 to 16. Frame bit 0 is the first leading bit. Bits 4 to 15 are data bits 11 down to 0.
- R6: With edge_sel_i = 1, frame bit 0 is taken on the first falling edge and frame bit k on the k-th rising edge, for k = 1 to 15. The 16th rising edge takes nothing. Both modes give the same word from a converter that advances on falling edges.
- R7: A 16-clock frame drives valid_o high for exactly the one cycle in which cs_n_o returns to 1, with result_o holding the twelve data bits.
- R8: If any of the four leading bits is 1, err_o is high in the same cycle as valid_o, and result_o still carries the data bits.
- R9: A frame shorter than 16 clocks raises neither valid_o nor err_o and leaves result_o unchanged.
- R10: After cs_n_o rises it stays high for 2·H system cycles. busy_o stays 1 from acceptance to the end of that gap. A start_i seen while busy_o is 1 has no effect.
- R11: Changes on div_i, len_i and edge_sel_i during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request one frame |
| div_i | input | 8 | Serial clock half period in system cycles |
| len_i | input | 5 | Serial clocks per frame (16 for a full frame) |
| edge_sel_i | input | 1 | 0: capture on falling edges, 1: capture on rising edges |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | Frame or post-frame gap in progress |
| result_o | output | 12 | Last delivered data word |
| valid_o | output | 1 | One-cycle strobe for a new result |
| err_o | output | 1 | One-cycle strobe: a leading bit was not zero |

## Verification
Two events can land on the same system cycle. One is the end of a frame, where chip-select rises, the result is delivered and the error flag may be set. The other is a new start request, which must be refused because the post-frame gap has only just begun. The bench places a start pulse exactly on the edge where chip-select returns high. It also holds start high across the whole gap, so the refusal and the later acceptance both happen at a known edge. A reference model tracks the frame by elapsed cycles and judges chip-select, the serial clock, busy and the delivered word on every clock. The same collision is tried against an aborted frame, where nothing may be delivered.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } rd_state_t;

  // Effective half period: zero is promoted to one system cycle.
  function automatic int half_cycles(input int div);
    return (div < 1) ? 1 : div;
  endfunction

  // Effective frame length: zero or too long means a full frame.
  function automatic int frame_clocks(input int len, input int full);
    return (len < 1 || len > full) ? full : len;
  endfunction

endpackage

// File: rtl/sar_clkgen.sv
module sar_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             fall_ev,
  output logic             rise_ev
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick    = run && (cnt == half - 1'b1);
  assign fall_ev = tick && sclk;
  assign rise_ev = tick && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_rd_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LEN_W      = 5,
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [LEN_W-1:0] len,
  input  logic             mode,
  input  logic             rise_ev,
  output logic             run,
  output logic             busy,
  output logic             accept_ev,
  output logic             end_ev,
  output logic             full_end,
  output logic [DIV_W-1:0] half_q,
  output logic             mode_q
);

  localparam int GAP_W = DIV_W + 1;

  rd_state_t        state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] rcnt;
  logic [GAP_W-1:0] gcnt;
  logic             gap_done;

  assign run       = (state == ST_FRAME);
  assign busy      = (state != ST_IDLE);
  assign accept_ev = start && (state == ST_IDLE);
  assign end_ev    = run && rise_ev && (rcnt == len_q - 1'b1);
  assign full_end  = end_ev && (len_q == LEN_W'(FRAME_BITS));
  assign gap_done  = (state == ST_GAP) && (gcnt == {half_q, 1'b0} - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      len_q  <= '0;
      half_q <= '0;
      mode_q <= 1'b0;
      rcnt   <= '0;
      gcnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept_ev) begin
            state  <= ST_FRAME;
            half_q <= DIV_W'(half_cycles(int'(div)));
            len_q  <= LEN_W'(frame_clocks(int'(len), FRAME_BITS));
            mode_q <= mode;
            rcnt   <= '0;
          end
        end
        ST_FRAME: begin
          if (end_ev) begin
            state <= ST_GAP;
            gcnt  <= '0;
          end else if (rise_ev) begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_done) state <= ST_IDLE;
          else          gcnt  <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  mode,
  input  logic                  fall_ev,
  input  logic                  rise_ev,
  input  logic                  sdata,
  output logic                  cap_ev,
  output logic [FRAME_BITS-1:0] word
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] ccnt;
  logic             room;

  assign room = (ccnt < CNT_W'(FRAME_BITS));

  // Rising mode: bit 0 was launched by chip-select, so it is taken on
  // the first falling edge; every later bit is taken on a rising edge.
  generate
    if (1) begin : g_sel
      always_comb begin
        if (mode) cap_ev = (fall_ev && ccnt == '0) || (rise_ev && room);
        else      cap_ev = fall_ev && room;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt <= '0;
      word <= '0;
    end else if (clear) begin
      ccnt <= '0;
    end else if (cap_ev) begin
      ccnt <= ccnt + 1'b1;
      word <= {word[FRAME_BITS-2:0], sdata};
    end
  end

endmodule

// File: rtl/sar_frame_reader.sv
module sar_frame_reader #(
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 5,
  parameter int LEAD_BITS = 4,
  parameter int DATA_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              edge_sel_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              err_o
);

  localparam int FRAME_BITS = LEAD_BITS + DATA_W;

  logic                  run;
  logic                  accept_ev;
  logic                  end_ev;
  logic                  full_end;
  logic                  fall_ev;
  logic                  rise_ev;
  logic                  cap_ev;
  logic                  mode_q;
  logic                  lead_bad;
  logic [DIV_W-1:0]      half_q;
  logic [FRAME_BITS-1:0] word;

  sar_sequencer #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .FRAME_BITS(FRAME_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .div(div_i), .len(len_i),
    .mode(edge_sel_i), .rise_ev(rise_ev), .run(run), .busy(busy_o),
    .accept_ev(accept_ev), .end_ev(end_ev), .full_end(full_end),
    .half_q(half_q), .mode_q(mode_q)
  );

  sar_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q),
    .sclk(sclk_o), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sar_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(accept_ev), .mode(mode_q),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .sdata(sdata_i),
    .cap_ev(cap_ev), .word(word)
  );

  assign cs_n_o   = !run;
  assign lead_bad = |word[FRAME_BITS-1:DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= full_end;
      err_o   <= full_end && lead_bad;
      if (full_end) result_o <= word[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/sar_frame_reader_chk.sv
module sar_frame_reader_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              err_o,
  input logic              accept_ev,
  input logic              end_ev,
  input logic              full_end,
  input logic              rise_ev
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (!cs_n_o && sclk_o && busy_o));

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_end_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_ev |-> rise_ev);

  assert_valid_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);

  assert_short_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && !full_end) |=> (!valid_o && !err_o));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

  assert_cs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !accept_ev);

endmodule

bind sar_frame_reader sar_frame_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o),
  .err_o(err_o), .accept_ev(accept_ev), .end_ev(end_ev),
  .full_end(full_end), .rise_ev(rise_ev)
);

// File: tb/test_sar_frame_reader.sv
`timescale 1ns/1ps
module test_sar_frame_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  div_i = 8'd2;
  logic [4:0]  len_i = 5'd16;
  logic        edge_sel_i = 1'b0;
  logic        sdata_i = 1'b1;
  logic        cs_n_o, sclk_o, busy_o, valid_o, err_o;
  logic [11:0] result_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sar_frame_reader i_sar_frame_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
    .len_i(len_i), .edge_sel_i(edge_sel_i), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference model: elapsed edges since acceptance.
  bit          m_on = 0;
  int          m_t = 0, m_h = 1, m_l = 16;
  logic [15:0] m_word = '0;
  logic [15:0] cur_word = '0;
  int          m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_res = 0;
    end else if (!m_on) begin
      if (start_i) begin  // R2 acceptance
        m_on = 1; m_t = 0;
        m_h = (div_i == 0) ? 1 : int'(div_i);                     // R3
        m_l = (len_i == 0 || len_i > 16) ? 16 : int'(len_i);       // R4
        m_word = cur_word;
      end
    end else begin
      m_t++;
      if (m_t == 2*m_l*m_h && m_l == 16) m_res = int'(m_word[11:0]);
      if (m_t == 2*m_l*m_h + 2*m_h) m_on = 0;                      // R10
    end
  end

  // Converter model: first bit on chip-select fall, advance on sclk fall.
  int   ptr = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      bit end_c;
      int e_cs, e_sclk, e_val;
      end_c  = m_on && (m_t >= 2*m_l*m_h);
      e_cs   = (!m_on || end_c) ? 1 : 0;
      e_sclk = (!m_on || end_c || ((m_t / m_h) % 2 == 0)) ? 1 : 0;
      e_val  = (m_on && m_t == 2*m_l*m_h && m_l == 16) ? 1 : 0;
      chk("R2/R4 cs_n", int'(cs_n_o), e_cs);
      chk("R3 sclk", int'(sclk_o), e_sclk);
      chk("R10 busy", int'(busy_o), int'(m_on));
      chk("R7/R9 valid", int'(valid_o), e_val);
      chk("R8 err", int'(err_o), (e_val == 1 && m_word[15:12] != 0) ? 1 : 0);
      chk("R5/R6/R11 result", int'(result_o), m_res);
    end
    if (!cs_n_o && p_cs) ptr = 0;
    else if (!cs_n_o && p_sclk && !sclk_o) ptr++;
    p_cs = cs_n_o; p_sclk = sclk_o;
    sdata_i <= cs_n_o ? 1'b1 : ((ptr < 16) ? m_word[15 - ptr] : 1'b0);
  end

  task automatic pulse_start;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (m_on) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int dv, input int ln, input bit md);
    @(negedge clk);
    cur_word = w; div_i = 8'(dv); len_i = 5'(ln); edge_sel_i = md;
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", int'(cs_n_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", int'(cs_n_o), 1);
    chk("R1 sclk", int'(sclk_o), 1);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 result", int'(result_o), 0);

    frame(16'h0ABC, 2, 16, 0);   // R5 falling capture
    frame(16'h0C35, 3, 16, 1);   // R6 rising capture
    frame(16'h8123, 2, 16, 0);   // R8 bad leading bit, falling
    frame(16'h1FFE, 1, 16, 1);   // R8 bad leading bit, rising
    frame(16'h0555, 0, 0, 0);    // R3/R4 div 0 -> 1, len 0 -> 16
    frame(16'h0777, 2, 10, 0);   // R9 aborted frame
    frame(16'h0F0F, 1, 31, 1);   // R4 over-long length -> 16
    frame(16'h0001, 2, 1, 1);    // R9 one-clock abort

    // R11: change settings mid-frame
    @(negedge clk);
    cur_word = 16'h0246; div_i = 8'd2; len_i = 5'd16; edge_sel_i = 1'b0;
    pulse_start();
    repeat (5) @(negedge clk);
    div_i = 8'd5; len_i = 5'd4; edge_sel_i = 1'b1;
    wait_idle();

    // R10: start mid-frame, and on the edge chip-select rises
    @(negedge clk);
    cur_word = 16'h0ACE; div_i = 8'd2; len_i = 5'd16; edge_sel_i = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    while (!(m_on && m_t == 2*16*2 - 1)) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wait_idle();

    // R2/R10: start held high across the gap after an aborted frame
    @(negedge clk);
    cur_word = 16'h0999; div_i = 8'd3; len_i = 5'd5; edge_sel_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    cur_word = 16'h0BEE; len_i = 5'd16;
    while (!(m_on && m_t == 0 && m_word == 16'h0BEE)) @(negedge clk);
    start_i = 1'b0;
    wait_idle();

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule